// File: doc/BRIEF.md
# Interval Pulse Generator

This block turns a stream of time-counter ticks into periodic output pulses that stay locked to the nanosecond time base. Each tick stands for one nominal period of the time counter, and that period is given in nanoseconds on an input. Each generator holds a programmed interval in nanoseconds and a down-counter. On every tick the counter loses one nominal period. When less than one period remains, the generator expires, reloads from its interval register and starts an output pulse.

Software loads the interval as the wanted pulse spacing minus one nominal period. For example, with a 10 ns period, the value 999,999,990 gives one pulse per second and 99,990 gives 10 kHz. Each pulse lasts one output-clock period, which is the prescale count of ticks. Every expiry also sets a sticky flag. Software clears the flag by writing a one to it, and the flag can raise a shared interrupt. Two generators are always built. A third one is a build option.

Top module: `interval_pulse_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after, all pulse outputs, all event flags and `irq_o` are 0. All interval registers and interrupt enables are 0.
- R2: After an interval I is written, the first tick loads the counter and makes no pulse. From then on the generator expires every floor(I/P)+1 ticks, where P is `period_i`. So I = (N-1)*P gives exactly N ticks between expiries.
- R3: An expiry tick drives the pulse high from the next cycle. The pulse stays high for `prescale_i` ticks, counting the value at the expiry. Each further tick lowers the remaining width by one. An expiry during a pulse restarts the full width. A prescale of 0 gives no pulse.
- R4: A generator whose interval register holds 0 never expires. Its pulse and its event flag stay 0.
- R5: Writing an interval restarts that generator's countdown from the new value on the next tick. It does not wait for the old interval to run out.
- R6: Each expiry sets that generator's event flag, and the flag holds until cleared. A write to address 5 clears every flag whose data bit (bit g for generator g) is 1. An expiry in the same cycle wins over the clear.
- R7: `irq_o` is 1 whenever some event flag is set and its enable bit is also set. Enable bit g is data bit g of the last write to address 4.
- R8: Address g (0, 1, 2) writes the interval of generator g. Address 2 and generator 2 exist only when `HAS_GEN3` is 1. Writes to addresses 3, 6 and 7 change no state.
- R9: In a cycle with `tick_i` low, no counter, pulse width or pulse output changes, and no event flag becomes set.

Ports (widths at default parameters; NUM_GEN = 3 with the third generator built):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-counter tick, one nominal period per tick |
| period_i | input | 8 | Nominal tick period in ns, nonzero |
| prescale_i | input | 16 | Pulse width in ticks (output-clock divider) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0-2 interval, 4 irq enable, 5 flag clear |
| wr_data_i | input | 32 | Register write data |
| pulse_o | output | 3 | Pulse output, one bit per generator |
| event_o | output | 3 | Sticky expiry flags, one bit per generator |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
The main function is driven with three interval patterns:
- An exact multiple of the period, with ticks on every cycle. This shows whether the spacing of N ticks has the "minus one period" offset right.
- A value that is not a multiple of the period. This separates a "less than" expiry test from a "less than or equal" one, through the floor(I/P)+1 spacing.
- A reprogramming in the middle of a count. This shows whether the restart happens at once or only after the old interval runs out.

A second pass sends the ticks sparsely, to tell counting per tick apart from counting per clock. Prescale values larger than the spacing, and a prescale of zero, separate a restarted pulse from a pulse stretched across expiries, and a present pulse from a missing one.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_IVL0   = 3'd0,
        SEL_IVL1   = 3'd1,
        SEL_IVL2   = 3'd2,
        SEL_IRQ_EN = 3'd4,
        SEL_EV_CLR = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic pulse;
        logic flag;
    } chan_stat_t;

    function automatic int unsigned gen_count(input bit with_third);
        return with_third ? 3 : 2;
    endfunction

endpackage

// File: rtl/ipg_regs.sv
module ipg_regs
    import ipg_pkg::*;
#(
    parameter int unsigned NUM_GEN = 3,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    output logic [NUM_GEN-1:0][CNT_W-1:0]   interval_o,
    output logic [NUM_GEN-1:0]              load_req_o,
    output logic [NUM_GEN-1:0]              irq_en_o,
    output logic [NUM_GEN-1:0]              flag_clr_o
);

    logic unused_data;
    assign unused_data = ^wr_data_i;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_ivl
        logic hit;
        assign hit           = wr_en_i && (wr_addr_i == ADDR_W'(g));
        assign load_req_o[g] = hit;

        always_ff @(posedge clk) begin
            if (rst) begin
                interval_o[g] <= '0;
            end else if (hit) begin
                interval_o[g] <= wr_data_i[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_o <= '0;
        end else if (wr_en_i && (wr_addr_i == SEL_IRQ_EN)) begin
            irq_en_o <= wr_data_i[NUM_GEN-1:0];
        end
    end

    assign flag_clr_o = (wr_en_i && (wr_addr_i == SEL_EV_CLR)) ?
                        wr_data_i[NUM_GEN-1:0] : '0;

endmodule

// File: rtl/ipg_chan.sv
module ipg_chan
    import ipg_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PER_W = 8,
    parameter int unsigned PRS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [PRS_W-1:0]  prescale_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic              load_req_i,
    input  logic              flag_clr_i,
    output chan_stat_t        stat_o
);

    logic [CNT_W-1:0] count_q;
    logic             pend_q;
    logic [PRS_W-1:0] width_q;
    logic             flag_q;

    logic [CNT_W-1:0] step;
    logic             armed;
    logic             expire;

    assign step   = CNT_W'(period_i);
    assign armed  = |interval_i;
    assign expire = tick_i && !pend_q && armed && (count_q < step);

    // countdown: a pending load wins, else reload on expiry, else subtract
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick_i) begin
            if (pend_q || expire) begin
                count_q <= interval_i;
            end else if (armed) begin
                count_q <= count_q - step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (load_req_i) begin
            pend_q <= 1'b1;
        end else if (tick_i) begin
            pend_q <= 1'b0;
        end
    end

    // pulse width counts down in ticks, restarted by each expiry
    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= '0;
        end else if (expire) begin
            width_q <= prescale_i;
        end else if (tick_i && (width_q != '0)) begin
            width_q <= width_q - PRS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (flag_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign stat_o.pulse = |width_q;
    assign stat_o.flag  = flag_q;

endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
    import ipg_pkg::*;
#(
    parameter bit          HAS_GEN3 = 1'b1,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned PER_W    = 8,
    parameter int unsigned PRS_W    = 16,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned NUM_GEN = gen_count(HAS_GEN3)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [PER_W-1:0]    period_i,
    input  logic [PRS_W-1:0]    prescale_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [NUM_GEN-1:0]  pulse_o,
    output logic [NUM_GEN-1:0]  event_o,
    output logic                irq_o
);

    logic [NUM_GEN-1:0][CNT_W-1:0] interval;
    logic [NUM_GEN-1:0]            load_req;
    logic [NUM_GEN-1:0]            irq_en;
    logic [NUM_GEN-1:0]            flag_clr;
    chan_stat_t                    stat [NUM_GEN];

    ipg_regs #(
        .NUM_GEN (NUM_GEN),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .interval_o (interval),
        .load_req_o (load_req),
        .irq_en_o   (irq_en),
        .flag_clr_o (flag_clr)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        ipg_chan #(
            .CNT_W (CNT_W),
            .PER_W (PER_W),
            .PRS_W (PRS_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .tick_i     (tick_i),
            .period_i   (period_i),
            .prescale_i (prescale_i),
            .interval_i (interval[g]),
            .load_req_i (load_req[g]),
            .flag_clr_i (flag_clr[g]),
            .stat_o     (stat[g])
        );
        assign pulse_o[g] = stat[g].pulse;
        assign event_o[g] = stat[g].flag;
    end

    assign irq_o = |(event_o & irq_en);

endmodule

// File: rtl/interval_pulse_gen_chk.sv
module interval_pulse_gen_chk #(
    parameter int unsigned NUM_GEN = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_i,
    input logic [NUM_GEN-1:0] pulse_o,
    input logic [NUM_GEN-1:0] event_o,
    input logic               irq_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pulse_o == '0 && event_o == '0 && !irq_o));

    // R9
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(pulse_o));

    // R9
    flag_set_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ((event_o & ~$past(event_o)) == '0));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (event_o != '0));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_pe
        // R6
        pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[g]) |-> event_o[g]);
    end

endmodule

bind interval_pulse_gen interval_pulse_gen_chk #(.NUM_GEN(NUM_GEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .pulse_o (pulse_o),
    .event_o (event_o),
    .irq_o   (irq_o)
);

// File: tb/interval_pulse_gen_bench.sv
module interval_pulse_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [7:0]  period_i = 8'd10;
    logic [15:0] prescale_i = 16'd0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = 3'd0;
    logic [31:0] wr_data_i = 32'd0;
    logic [2:0]  pulse_o;
    logic [2:0]  event_o;
    logic        irq_o;

    always #4 clk = ~clk;

    interval_pulse_gen u_interval_pulse_gen (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .period_i   (period_i),
        .prescale_i (prescale_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .pulse_o    (pulse_o),
        .event_o    (event_o),
        .irq_o      (irq_o)
    );

    typedef struct {
        logic [2:0] pulse;
        logic [2:0] ev;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    int unsigned prs   = 0;
    int unsigned per   = 10;

    int unsigned m_int  [3];
    int unsigned m_left [3];
    bit          m_pend [3];
    int unsigned m_pw   [3];
    logic [2:0]  m_ev = '0;
    logic [2:0]  m_en = '0;

    task automatic check(input string tag, input string what,
                         input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // driver: sets inputs for the coming edge and queues the expected result
    task automatic drive(input logic t, input logic w, input logic [2:0] a,
                         input logic [31:0] d, input string tag);
        logic [2:0] fire;
        logic [2:0] clr;
        exp_t e;
        @(negedge clk);
        tick_i = t; wr_en_i = w; wr_addr_i = a; wr_data_i = d;
        prescale_i = prs[15:0];
        fire = '0;
        clr  = (w && a == 3'd5) ? d[2:0] : 3'b000;
        if (t) begin
            for (int g = 0; g < 3; g++) begin
                if (m_pend[g]) begin
                    m_left[g] = m_int[g] / per + 1;
                    m_pend[g] = 1'b0;
                end else if (m_int[g] != 0) begin
                    m_left[g] = m_left[g] - 1;
                    if (m_left[g] == 0) begin
                        fire[g]   = 1'b1;
                        m_left[g] = m_int[g] / per + 1;
                    end
                end
                if (fire[g]) m_pw[g] = prs;
                else if (m_pw[g] > 0) m_pw[g] = m_pw[g] - 1;
            end
        end
        for (int g = 0; g < 3; g++) begin
            if (fire[g]) m_ev[g] = 1'b1;
            else if (clr[g]) m_ev[g] = 1'b0;
        end
        if (w && a < 3'd3) begin
            m_int[a]  = d;
            m_pend[a] = 1'b1;
        end
        if (w && a == 3'd4) m_en = d[2:0];
        for (int g = 0; g < 3; g++) e.pulse[g] = (m_pw[g] != 0);
        e.ev  = m_ev;
        e.irq = |(m_ev & m_en);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares each edge's outputs with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "pulse", pulse_o, e.pulse);
                check(e.tag, "event", event_o, e.ev);
                check(e.tag, "irq", {2'b00, irq_o}, {2'b00, e.irq});
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 3; g++) begin
            m_int[g] = 0; m_left[g] = 0; m_pend[g] = 1'b0; m_pw[g] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state straight after reset
        check("R1", "pulse", pulse_o, 3'b000);
        check("R1", "event", event_o, 3'b000);
        check("R1", "irq", {2'b00, irq_o}, 3'b000);

        // R4: nothing programmed, ticks give no expiry
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R4");

        // R2: 40 ns interval, 10 ns period -> 5 ticks apart, width 2
        prs = 2;
        drive(1'b0, 1'b1, 3'd0, 32'd40, "R2");
        for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R2");

        // R9: sparse ticks, state frozen between them
        for (int i = 0; i < 36; i++) drive(i % 3 == 0, 1'b0, 3'd0, 32'd0, "R9");

        // R3: non-multiple 25 -> 3 ticks apart, width 4 restarts each time
        prs = 4;
        drive(1'b0, 1'b1, 3'd1, 32'd25, "R3");
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R3");
        // R3: zero prescale gives flags but no pulse on generator 2
        prs = 0;
        drive(1'b0, 1'b1, 3'd2, 32'd50, "R3");
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R3");
        prs = 1;

        // R5: reprogram generator 0 mid count, then tick
        drive(1'b1, 1'b0, 3'd0, 32'd0, "R5");
        drive(1'b1, 1'b1, 3'd0, 32'd90, "R5");
        for (int i = 0; i < 25; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R5");

        // R7: enable generators 0 and 2 onto the interrupt
        drive(1'b0, 1'b1, 3'd4, 32'd5, "R7");
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R7");

        // R6: write-one-to-clear, sometimes together with ticks
        drive(1'b0, 1'b1, 3'd5, 32'd2, "R6");
        for (int i = 0; i < 16; i++) drive(i % 2 == 1, i % 4 == 1, 3'd5, 32'd7, "R6");
        drive(1'b0, 1'b1, 3'd5, 32'd7, "R6");

        // R8: unused addresses leave every state untouched
        drive(1'b0, 1'b1, 3'd3, 32'hFFFF_FFFF, "R8");
        drive(1'b0, 1'b1, 3'd6, 32'hFFFF_FFFF, "R8");
        drive(1'b0, 1'b1, 3'd7, 32'hFFFF_FFFF, "R8");
        for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R8");

        // R4: zero interval turns generator 1 off
        drive(1'b0, 1'b1, 3'd1, 32'd0, "R4");
        drive(1'b0, 1'b1, 3'd5, 32'd7, "R4");
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 3'd0, 32'd0, "R4");

        // R1: reset in the middle of activity
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1", "pulse", pulse_o, 3'b000);
        check("R1", "event", event_o, 3'b000);
        check("R1", "irq", {2'b00, irq_o}, 3'b000);
        @(negedge clk);
        rst = 1'b0;
        tick_i = 1'b0;
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule